// File: doc/BRIEF.md
# Chained Dual Interval Timer

This block holds two 16-bit down-counting interval timers, each with its own reload latch and control register. Software reaches them over a plain byte-wide register bus. Timer A always counts system clocks. Timer B counts either system clocks or the underflows of Timer A, so the two can be chained into one longer interval. Each timer runs either continuously or as a one-shot. When a running count expires, the counter is refilled from its latch and does not rest at zero.

Every underflow sets a flag in an interrupt control register. A mask held in the same register decides which flags drive the active-low interrupt output. Reading the interrupt control register returns the flags and clears them. A read that lands just before a Timer B underflow swallows that interrupt. A build parameter picks one of two revision timings. The older revision asserts the interrupt one clock later than the newer one. The counting itself is the same in both.

The bus is plain control access, with no flow control. A write completes in the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational while `bus_sel` is high and `bus_wr` is low. The side effects of a read take place at the closing edge of that cycle.

Top module: `chained_timer_pair`

## Requirements
- R1: After reset, both counters and both latches hold 0xFFFF, both control registers read 0x00, the interrupt register reads 0x00 and `irq_n` is high.
- R2: In clock mode with a latch N of at least 1, a force-load and start makes the counter show N, then N-1 down to 1 on successive clocks. On the next clock it shows N again and keeps N for a second clock. From then on it repeats with a period of N+1 clocks and never shows zero.
- R3: The Timer A latch sits at offsets 0x4 (low byte) and 0x5 (high byte), and the Timer B latch at 0x6 and 0x7. Reads at these offsets return the counter. A low-byte write changes only the latch. A high-byte write while the timer is stopped also loads the whole latch into the counter. A high-byte write while the timer runs changes only the latch.
- R4: Control A sits at 0xE and control B at 0xF. Bit 0 starts the timer and bit 3 selects one-shot. Writing bit 4 high loads the latch into the counter in that same edge. Bit 4 always reads back as 0.
- R5: In one-shot mode an underflow refills the counter from the latch and clears bit 0 of the control register. Bit 3 stays set.
- R6: Control B bits 6:5 = 2'b11 makes Timer B count Timer A underflows. Any other value counts clocks. When chained and the Timer A latch is not zero, Timer B steps down to 0 and holds it until the next Timer A underflow, which refills it from its latch.
- R7: A Timer A latch of 0 makes Timer A underflow on every clock. Chained Timer B then follows the R2 sequence and never shows zero.
- R8: The interrupt register sits at 0xD. A read returns bit 0 for a Timer A underflow, bit 1 for a Timer B underflow, and bit 7 when any flagged source is also masked. The flags clear at the edge that ends the read, but an underflow in that same edge still sets its flag.
- R9: A write to 0xD with bit 7 high sets the mask bits given in bits 1:0. With bit 7 low it clears them. An unmasked underflow sets its flag but leaves `irq_n` high.
- R10: `irq_n` is active low and stays low until the interrupt register is read.
- R11: With the newer timing, `irq_n` falls right after the edge in which a masked underflow happens. With the older timing it falls one clock later. The counter values are identical in both.
- R12: A Timer B underflow in the first or second edge after an interrupt-register read sets no flag and does not drive `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is selected |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest state to reach from the pins is an interrupt-register read that lands exactly one or two edges before a Timer B underflow. The bench gets there by force-loading Timer B with a known latch and counting clocks from that write edge. It then places the read so it closes the cycle before the underflow edge, and later confirms that a read placed further away does not lose the next interrupt. Chaining with a zero Timer A latch is reached the same way: both timers are loaded while stopped, and Timer B's low byte is read on every clock after the start.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;
  localparam int NSRC   = 2;

  localparam logic [ADDR_W-1:0] OFF_TA_LO = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_TA_HI = 4'h5;
  localparam logic [ADDR_W-1:0] OFF_TB_LO = 4'h6;
  localparam logic [ADDR_W-1:0] OFF_TB_HI = 4'h7;
  localparam logic [ADDR_W-1:0] OFF_IRQ   = 4'hD;
  localparam logic [ADDR_W-1:0] OFF_CTL_A = 4'hE;
  localparam logic [ADDR_W-1:0] OFF_CTL_B = 4'hF;

  // control bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_ONCE  = 3;
  localparam int CB_LOAD  = 4;
  localparam int CB_SRC_L = 5;
  localparam int CB_SRC_H = 6;
  localparam logic [1:0] SRC_CHAIN = 2'b11;
endpackage

// File: rtl/ctp_timer.sv
module ctp_timer
  import ctp_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int HAS_CHAIN = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ext_uf,
  input  logic              ext_latch_zero,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  latch_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              run_o,
  output logic              oneshot_o,
  output logic              uf_o
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] cnt_q, latch_q;
  logic             run_q, oneshot_q, hold_q;
  logic [1:0]       src_q;
  logic             chained, fast, tick, force_ld, uf;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[BYTE_W-1], wdata[2:1]};

  assign chained  = (HAS_CHAIN != 0) && (src_q == SRC_CHAIN);
  // back-to-back ticks use the refill-and-hold sequence
  assign fast     = !chained || ext_latch_zero;
  assign tick     = run_q && (chained ? ext_uf : 1'b1);
  assign force_ld = ctrl_we && wdata[CB_LOAD];

  always_comb begin
    uf = 1'b0;
    if (tick && !force_ld) begin
      if (fast) uf = !hold_q && (cnt_q <= CNT_W'(1));
      else      uf = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
    end else begin
      if (lo_we) latch_q[BYTE_W-1:0] <= wdata;
      if (hi_we) latch_q[CNT_W-1:BYTE_W] <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      hold_q <= 1'b0;
    end else if (force_ld) begin
      cnt_q  <= latch_q;
      hold_q <= 1'b0;
    end else if (hi_we && !run_q) begin
      cnt_q  <= {wdata[HI_W-1:0], latch_q[BYTE_W-1:0]};
      hold_q <= 1'b0;
    end else if (tick) begin
      if (uf) begin
        cnt_q  <= latch_q;
        hold_q <= fast && (latch_q != '0);
      end else if (fast && hold_q) begin
        hold_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_q - CNT_W'(1);
        hold_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
      src_q     <= '0;
    end else if (ctrl_we) begin
      run_q     <= wdata[CB_RUN];
      oneshot_q <= wdata[CB_ONCE];
      src_q     <= wdata[CB_SRC_H:CB_SRC_L];
    end else if (uf && oneshot_q) begin
      run_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o = '0;
    ctrl_o[CB_RUN]  = run_q;
    ctrl_o[CB_ONCE] = oneshot_q;
    if (HAS_CHAIN != 0) ctrl_o[CB_SRC_H:CB_SRC_L] = src_q;
  end

  assign cnt_o     = cnt_q;
  assign latch_o   = latch_q;
  assign run_o     = run_q;
  assign oneshot_o = oneshot_q;
  assign uf_o      = uf;
endmodule

// File: rtl/ctp_irq.sv
module ctp_irq
  import ctp_pkg::*;
#(
  parameter int OLD_REV = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   uf_i,
  input  logic              rd_i,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NSRC-1:0]   flags_o,
  output logic              irq_n_o
);
  logic [NSRC-1:0] flags_q, mask_q, uf_eff;
  logic [1:0]      guard_q;
  logic            irq_q, hit, irq_set;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[BYTE_W-2:NSRC];

  // Timer B underflow is swallowed for two edges after a read
  assign uf_eff = {uf_i[1] && (guard_q == 2'd0), uf_i[0]};
  assign hit    = |(uf_eff & mask_q);

  generate
    if (OLD_REV != 0) begin : g_late
      logic hit_d;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_d <= 1'b0;
        else        hit_d <= hit;
      end
      assign irq_set = hit_d;
    end else begin : g_early
      assign irq_set = hit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
      guard_q <= 2'd0;
    end else begin
      flags_q <= (rd_i ? '0 : flags_q) | uf_eff;
      irq_q   <= (rd_i ? 1'b0 : irq_q) | irq_set;
      if (rd_i)                guard_q <= 2'd2;
      else if (guard_q != 2'd0) guard_q <= guard_q - 2'd1;
      if (we_i) begin
        if (wdata[BYTE_W-1]) mask_q <= mask_q | wdata[NSRC-1:0];
        else                 mask_q <= mask_q & ~wdata[NSRC-1:0];
      end
    end
  end

  assign rdata_o = {|(flags_q & mask_q), {(BYTE_W-1-NSRC){1'b0}}, flags_q};
  assign flags_o = flags_q;
  assign irq_n_o = !irq_q;
endmodule

// File: rtl/chained_timer_pair.sv
module chained_timer_pair
  import ctp_pkg::*;
#(
  parameter int OLD_REV = 0,
  parameter int CNT_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq_n
);
  logic              do_wr, do_rd;
  logic [CNT_W-1:0]  cnt_a, cnt_b, latch_a, unused_latch_b;
  logic [BYTE_W-1:0] ctrl_a, ctrl_b, irq_rdata;
  logic              run_a, oneshot_a, uf_a, uf_b;
  logic              unused_run_b, unused_once_b;
  logic [NSRC-1:0]   flags;

  assign do_wr = bus_sel && bus_wr;
  assign do_rd = bus_sel && !bus_wr;

  ctp_timer #(.CNT_W(CNT_W), .HAS_CHAIN(0)) u_tmr_a (
    .clk(clk), .rst_n(rst_n),
    .lo_we(do_wr && bus_addr == OFF_TA_LO),
    .hi_we(do_wr && bus_addr == OFF_TA_HI),
    .ctrl_we(do_wr && bus_addr == OFF_CTL_A),
    .wdata(bus_wdata), .ext_uf(1'b0), .ext_latch_zero(1'b0),
    .cnt_o(cnt_a), .latch_o(latch_a), .ctrl_o(ctrl_a),
    .run_o(run_a), .oneshot_o(oneshot_a), .uf_o(uf_a)
  );

  ctp_timer #(.CNT_W(CNT_W), .HAS_CHAIN(1)) u_tmr_b (
    .clk(clk), .rst_n(rst_n),
    .lo_we(do_wr && bus_addr == OFF_TB_LO),
    .hi_we(do_wr && bus_addr == OFF_TB_HI),
    .ctrl_we(do_wr && bus_addr == OFF_CTL_B),
    .wdata(bus_wdata), .ext_uf(uf_a), .ext_latch_zero(latch_a == '0),
    .cnt_o(cnt_b), .latch_o(unused_latch_b), .ctrl_o(ctrl_b),
    .run_o(unused_run_b), .oneshot_o(unused_once_b), .uf_o(uf_b)
  );

  ctp_irq #(.OLD_REV(OLD_REV)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .uf_i({uf_b, uf_a}),
    .rd_i(do_rd && bus_addr == OFF_IRQ),
    .we_i(do_wr && bus_addr == OFF_IRQ),
    .wdata(bus_wdata), .rdata_o(irq_rdata),
    .flags_o(flags), .irq_n_o(irq_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (do_rd) begin
      case (bus_addr)
        OFF_TA_LO: bus_rdata = cnt_a[BYTE_W-1:0];
        OFF_TA_HI: bus_rdata = cnt_a[CNT_W-1:BYTE_W];
        OFF_TB_LO: bus_rdata = cnt_b[BYTE_W-1:0];
        OFF_TB_HI: bus_rdata = cnt_b[CNT_W-1:BYTE_W];
        OFF_IRQ:   bus_rdata = irq_rdata;
        OFF_CTL_A: bus_rdata = ctrl_a;
        OFF_CTL_B: bus_rdata = ctrl_b;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker
  import ctp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_n,
  input logic              uf_a,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  latch_a,
  input logic              run_a,
  input logic              oneshot_a,
  input logic [NSRC-1:0]   flags
);
  logic any_wr, rd_irq;
  assign any_wr = bus_sel && bus_wr;
  assign rd_irq = bus_sel && !bus_wr && (bus_addr == OFF_IRQ);

  p_no_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_wr && cnt_a != '0 && latch_a != '0) |=> (cnt_a != '0));

  p_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_a && !any_wr) |=> (cnt_a == $past(latch_a)));

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_a && oneshot_a && !any_wr) |=> !run_a);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uf_a |=> flags[0]);

  p_irq_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_irq) |=> !irq_n);
endmodule

bind chained_timer_pair ctp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .irq_n(irq_n), .uf_a(uf_a), .cnt_a(cnt_a),
  .latch_a(latch_a), .run_a(run_a), .oneshot_a(oneshot_a), .flags(flags)
);

// File: tb/chained_timer_pair_tb_top.sv
module chained_timer_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, wr;
  logic [3:0] addr;
  logic [7:0] wdata, rdata, rdata_old;
  logic       irq_new, irq_old;
  int         n_checks = 0;
  int         n_err = 0;

  localparam logic [3:0] A_LO = 4'h4, A_HI = 4'h5, B_LO = 4'h6, B_HI = 4'h7;
  localparam logic [3:0] ICR = 4'hD, CTA = 4'hE, CTB = 4'hF;

  // {latch, clocks after start edge, expected low byte}
  localparam int NV = 13;
  localparam logic [23:0] VECS [NV] = '{
    24'h05_00_05, 24'h05_03_02, 24'h05_04_01, 24'h05_05_05, 24'h05_06_05,
    24'h05_07_04, 24'h05_0C_05, 24'h03_02_01, 24'h03_03_03, 24'h03_04_03,
    24'h03_05_02, 24'h01_03_01, 24'h02_04_01
  };

  always #5 clk = ~clk;

  chained_timer_pair #(.OLD_REV(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_new));

  chained_timer_pair #(.OLD_REV(1)) dut_old_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_old), .irq_n(irq_old));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [7:0] d, output logic [7:0] d_old);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata; d_old = rdata_old;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, vo;
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_n", irq_new, 1);
    check("R1 irq_n old", irq_old, 1);
    brd(A_LO, v, vo); check("R1 counter A low", v, 8'hFF);
    brd(B_HI, v, vo); check("R1 counter B high", v, 8'hFF);
    brd(CTA, v, vo);  check("R1 control A", v, 0);
    brd(ICR, v, vo);  check("R1 interrupt reg", v, 0);

    // R2 counting sequence from the table
    for (int i = 0; i < NV; i++) begin
      bwr(CTA, 8'h00);
      bwr(A_LO, VECS[i][23:16]);
      bwr(A_HI, 8'h00);
      bwr(CTA, 8'h11);
      repeat (int'(VECS[i][15:8])) @(negedge clk);
      brd(A_LO, v, vo);
      check($sformatf("R2 latch %0d step %0d", VECS[i][23:16], VECS[i][15:8]),
            v, VECS[i][7:0]);
    end
    brd(CTA, v, vo); check("R4 load bit reads 0", v, 8'h01);

    // R3 latch write rules
    bwr(CTA, 8'h00);
    bwr(A_LO, 8'd100);
    bwr(A_HI, 8'h00);
    bwr(A_LO, 8'd40);
    brd(A_LO, v, vo); check("R3 low write keeps counter", v, 100);
    bwr(A_HI, 8'h00);
    brd(A_LO, v, vo); check("R3 high write loads when stopped", v, 40);
    bwr(CTA, 8'h01);
    bwr(A_LO, 8'd7);
    bwr(A_HI, 8'h00);
    brd(A_LO, v, vo); check("R3 running write leaves counter", v, 38);
    bwr(CTA, 8'h11);
    brd(A_LO, v, vo); check("R4 force load", v, 7);

    // R5 one-shot
    bwr(CTA, 8'h00);
    brd(ICR, v, vo);
    bwr(A_LO, 8'd3);
    bwr(A_HI, 8'h00);
    bwr(CTA, 8'h19);
    repeat (5) @(negedge clk);
    brd(CTA, v, vo);  check("R5 start bit cleared", v, 8'h08);
    brd(A_LO, v, vo); check("R5 refilled", v, 3);
    brd(ICR, v, vo);  check("R8 flag A", v, 8'h01);
    brd(ICR, v, vo);  check("R8 read clears", v, 8'h00);

    // R11 / R10 revision timing and hold
    bwr(ICR, 8'h81);
    bwr(A_LO, 8'd4);
    bwr(A_HI, 8'h00);
    bwr(CTA, 8'h11);
    repeat (4) @(negedge clk);
    check("R11 new rev asserts", irq_new, 0);
    check("R11 old rev not yet", irq_old, 1);
    @(negedge clk);
    check("R11 old rev asserts", irq_old, 0);
    check("R10 irq held", irq_new, 0);
    brd(ICR, v, vo);
    check("R8 masked flag read", v, 8'h81);
    check("R11 old rev read", vo, 8'h81);
    check("R10 released new", irq_new, 1);
    check("R10 released old", irq_old, 1);
    bwr(CTA, 8'h00);
    brd(A_LO, v, vo);
    check("R11 same count new", v, 2);
    check("R11 same count old", vo, 2);

    // R9 mask clear
    bwr(ICR, 8'h01);
    bwr(CTA, 8'h11);
    repeat (6) @(negedge clk);
    check("R9 unmasked no irq", irq_new, 1);
    bwr(CTA, 8'h00);
    brd(ICR, v, vo); check("R9 flag set without mask", v, 8'h01);

    // R6 chaining, Timer A latch 1
    bwr(CTB, 8'h00);
    bwr(B_LO, 8'd3);
    bwr(B_HI, 8'h00);
    bwr(A_LO, 8'd1);
    bwr(A_HI, 8'h00);
    bwr(CTB, 8'h61);
    bwr(CTA, 8'h11);
    repeat (5) @(negedge clk);
    brd(B_LO, v, vo); check("R6 B reaches zero", v, 0);
    brd(B_LO, v, vo); check("R6 B holds zero", v, 0);
    brd(B_LO, v, vo); check("R6 B refilled", v, 3);
    brd(ICR, v, vo);  check("R8 both flags", v, 8'h03);

    // R7 chaining, Timer A latch 0
    bwr(CTA, 8'h00);
    bwr(CTB, 8'h00);
    bwr(A_LO, 8'd0);
    bwr(A_HI, 8'h00);
    bwr(B_LO, 8'd3);
    bwr(B_HI, 8'h00);
    bwr(CTB, 8'h61);
    bwr(CTA, 8'h01);
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      int exp_v;
      exp_v = (k % 4 == 0) ? 2 : (k % 4 == 1) ? 1 : 3;
      brd(B_LO, v, vo);
      check($sformatf("R7 chained step %0d", k + 1), v, exp_v);
    end

    // R12 lost interrupt
    bwr(CTA, 8'h00);
    bwr(CTB, 8'h00);
    brd(ICR, v, vo);
    bwr(ICR, 8'h82);
    bwr(B_LO, 8'd6);
    bwr(B_HI, 8'h00);
    bwr(CTB, 8'h11);
    repeat (4) @(negedge clk);
    brd(ICR, v, vo);
    @(negedge clk);
    check("R12 irq suppressed", irq_new, 1);
    @(negedge clk);
    check("R12 irq suppressed old", irq_old, 1);
    brd(ICR, v, vo); check("R12 flag lost", v, 8'h00);
    repeat (5) @(negedge clk);
    check("R12 later underflow kept", irq_new, 0);
    brd(ICR, v, vo); check("R12 flag B with mask", v, 8'h82);
    bwr(CTB, 8'h00);

    finish_run();
  end
endmodule